// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date as packed BCD bytes. A prescaler counts a free-running 32.768 kHz clock enable and issues one advance per second. Each advance steps seconds, minutes, hours, day of week, date, month and year, with the carries between them. Hours can be kept in a 24-hour format or in a 12-hour format with a PM flag. The date rolls over according to the length of each month, and February gets 29 days in leap years. The year is held as two digits, and a century bit in the month byte flips whenever the year wraps.

Software sets the time through a byte-wide write port that has one address per register. A write to the seconds byte restarts the prescaler, so the next second boundary falls one full second after that write. The block drives every register value out live. It also drives a one-cycle strobe after each advance and a half-second pulse, from which a 1 Hz square wave can be built.

Top module: `bcd_clock_calendar`

## Requirements
- R1: Seconds and minutes count 00 to 59 in packed BCD. Seconds wrap from 59 to 00, and that wrap advances minutes by one. Minutes wrap from 59 to 00, and that wrap advances hours.
- R2: When bit 6 of the hours byte is 0 the format is 24-hour: bits 5:0 hold BCD 00 to 23. A step from 23:59:59 gives 00:00:00 and advances the day. Counting never changes bit 6.
- R3: When bit 6 of the hours byte is 1 the format is 12-hour: bit 5 is the PM flag and bits 4:0 hold BCD 01 to 12. Hours run 12, 01, 02 up to 11. The PM flag toggles on the step from 11 to 12. The day advances only on the step from 11 PM to 12 AM.
- R4: Day of week counts 1 to 7. It steps once on each day advance and wraps from 7 to 1.
- R5: After the last day of the month, the date returns to 01 and the month advances. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the two-digit year is divisible by 4, 00 included, and 28 days otherwise. All other months have 31 days.
- R6: The month byte holds BCD 01 to 12 in bits 4:0 and the century bit in bit 7. Month 12 rolls to 01 and advances the year. Year 99 rolls to 00 and toggles the century bit. No other step changes the century bit.
- R7: An advance happens once every TICKS_PER_SEC cycles in which tick_en is high. Cycles with tick_en low are not counted. sec_strobe is high for exactly one cycle after each advance, in the same cycle that the new values appear.
- R8: A write to the seconds byte restarts the prescaler. The first advance after it comes exactly TICKS_PER_SEC enabled ticks after the write cycle. half_sec_pulse is high for one cycle, TICKS_PER_SEC/2 enabled ticks after the write cycle.
- R9: The write addresses are 0 for seconds, 1 for minutes, 2 for hours, 3 for day of week, 4 for date, 5 for month and 6 for year. Stored bits are masked as follows: 0x7F for seconds, minutes and hours, 0x07 for day of week, 0x3F for date, 0x9F for month, and the full byte for year. A write to address 7 changes nothing. Any write cycle drops the advance that would fall in that cycle, and the prescaler keeps counting, so the next advance comes one full second later.
- R10: While reset is asserted, the outputs read seconds 00, minutes 00, hours 0x00 (24-hour), day of week 1, date 01, month 0x01 and year 00, with both pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | 32.768 kHz clock enable, one cycle per tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| sec_o | output | 8 | Seconds, packed BCD |
| min_o | output | 8 | Minutes, packed BCD |
| hour_o | output | 8 | Hours with the format bit and the PM bit |
| dow_o | output | 8 | Day of week, 1 to 7 |
| date_o | output | 8 | Day of month, packed BCD |
| month_o | output | 8 | Month, packed BCD, with the century bit |
| year_o | output | 8 | Two-digit year, packed BCD |
| sec_strobe | output | 1 | One-cycle pulse after each advance |
| half_sec_pulse | output | 1 | One-cycle pulse at the middle of each second |

## Verification
The hardest case to reach from the ports is a write that lands in the exact cycle where an advance is due, because the prescaler phase cannot be observed. The bench fixes that phase with a seconds write, counts enabled ticks from there, and places a minutes write on the due cycle. It then checks that no strobe appears and that the next advance arrives one full second later. Calendar corners such as 31 December of year 99, February in years 00, 23 and 24, and the 12-hour noon and midnight steps are reached by loading the registers one second before the boundary.

// File: rtl/bcd_clk_pkg.sv
package bcd_clk_pkg;

  localparam int NUM_REGS     = 7;
  localparam int HR_MODE_BIT  = 6;
  localparam int HR_PM_BIT    = 5;
  localparam int MON_CENT_BIT = 7;

  typedef enum logic [2:0] {
    IDX_SEC   = 3'd0,
    IDX_MIN   = 3'd1,
    IDX_HOUR  = 3'd2,
    IDX_DOW   = 3'd3,
    IDX_DATE  = 3'd4,
    IDX_MONTH = 3'd5,
    IDX_YEAR  = 3'd6
  } clk_reg_idx_e;

  // Increment of a two-digit packed BCD value (no wrap handling).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = v + 8'd1;
    return r;
  endfunction

  // A two-digit year is a leap year when its binary value is a multiple of 4.
  function automatic logic is_leap(input logic [7:0] yr);
    logic [6:0] b;
    b = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    return (b[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_len(input logic [4:0] mon, input logic leap);
    logic [7:0] r;
    case (mon)
      5'h02:                      r = leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

  function automatic logic bcd_legal(input logic [7:0] v, input logic [7:0] maxv);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v <= maxv);
  endfunction

endpackage

// File: rtl/clk_prescaler.sv
module clk_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic restart,
  output logic one_sec,
  output logic half_pulse
);

  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] HALF_CNT = CW'(TICKS_PER_SEC / 2 - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          half_q, half_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)      cnt_d = '0;
    else if (tick_en) cnt_d = (cnt_q == LAST_CNT) ? '0 : cnt_q + 1'b1;
  end

  assign one_sec = tick_en && !restart && (cnt_q == LAST_CNT);
  assign half_d  = tick_en && !restart && (cnt_q == HALF_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
    end
  end

  assign half_pulse = half_q;

  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !one_sec); // R8

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    one_sec |=> !one_sec); // R7

endmodule

// File: rtl/bcd_time_chain.sv
module bcd_time_chain
  import bcd_clk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       we_sec,
  input  logic       we_min,
  input  logic       we_hour,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic       day_carry
);

  logic [7:0] sec_q, sec_d, min_q, min_d, hour_q, hour_d;
  logic       sec_wrap, min_wrap, hr_wrap;
  logic [7:0] hr_step, inc24, inc12;

  assign sec_wrap = (sec_q == 8'h59);
  assign min_wrap = (min_q == 8'h59);
  assign inc24    = bcd_inc({2'b00, hour_q[5:0]});
  assign inc12    = bcd_inc({3'b000, hour_q[4:0]});

  // Hours step for both formats
  always_comb begin
    hr_wrap = 1'b0;
    hr_step = hour_q;
    if (!hour_q[HR_MODE_BIT]) begin
      if (hour_q[5:0] == 6'h23) begin
        hr_step = 8'h00;
        hr_wrap = 1'b1;
      end else begin
        hr_step = {2'b00, inc24[5:0]};
      end
    end else begin
      if (hour_q[4:0] == 5'h12) begin
        hr_step = {2'b01, hour_q[HR_PM_BIT], 5'h01};
      end else if (hour_q[4:0] == 5'h11) begin
        hr_step = {2'b01, ~hour_q[HR_PM_BIT], 5'h12};
        hr_wrap = hour_q[HR_PM_BIT];
      end else begin
        hr_step = {2'b01, hour_q[HR_PM_BIT], inc12[4:0]};
      end
    end
  end

  always_comb begin
    sec_d = sec_q;
    if (we_sec)   sec_d = {1'b0, wr_data[6:0]};
    else if (adv) sec_d = sec_wrap ? 8'h00 : bcd_inc(sec_q);

    min_d = min_q;
    if (we_min)                min_d = {1'b0, wr_data[6:0]};
    else if (adv && sec_wrap)  min_d = min_wrap ? 8'h00 : bcd_inc(min_q);

    hour_d = hour_q;
    if (we_hour)                           hour_d = {1'b0, wr_data[6:0]};
    else if (adv && sec_wrap && min_wrap)  hour_d = hr_step;
  end

  assign day_carry = adv && sec_wrap && min_wrap && hr_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else begin
      sec_q  <= sec_d;
      min_q  <= min_d;
      hour_q <= hour_d;
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;

  AST_SEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && bcd_legal(sec_q, 8'h59)) |=> bcd_legal(sec_q, 8'h59)); // R1

  AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !sec_wrap && !we_min) |=> $stable(min_q)); // R1

  AST_MODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !we_hour) |=> (hour_q[HR_MODE_BIT] == $past(hour_q[HR_MODE_BIT]))); // R2

endmodule

// File: rtl/bcd_date_chain.sv
module bcd_date_chain
  import bcd_clk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_inc,
  input  logic       we_dow,
  input  logic       we_date,
  input  logic       we_month,
  input  logic       we_year,
  input  logic [7:0] wr_data,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);

  logic [7:0] dow_q, dow_d, date_q, date_d, month_q, month_d, year_q, year_d;
  logic [7:0] mlen, mon_inc;
  logic       date_wrap, mon_wrap, yr_wrap, cent_flip;

  assign mlen      = month_len(month_q[4:0], is_leap(year_q));
  assign date_wrap = (date_q == mlen);
  assign mon_wrap  = (month_q[4:0] == 5'h12);
  assign yr_wrap   = (year_q == 8'h99);
  assign mon_inc   = bcd_inc({3'b000, month_q[4:0]});
  assign cent_flip = date_wrap && mon_wrap && yr_wrap;

  always_comb begin
    dow_d = dow_q;
    if (we_dow)       dow_d = {5'b0, wr_data[2:0]};
    else if (day_inc) dow_d = (dow_q == 8'd7) ? 8'd1 : dow_q + 8'd1;

    date_d = date_q;
    if (we_date)      date_d = {2'b00, wr_data[5:0]};
    else if (day_inc) date_d = date_wrap ? 8'h01 : bcd_inc(date_q);

    month_d = month_q;
    if (we_month)
      month_d = {wr_data[7], 2'b00, wr_data[4:0]};
    else if (day_inc && date_wrap)
      month_d = {month_q[MON_CENT_BIT] ^ (mon_wrap && yr_wrap), 2'b00,
                 mon_wrap ? 5'h01 : mon_inc[4:0]};

    year_d = year_q;
    if (we_year)                             year_d = wr_data;
    else if (day_inc && date_wrap && mon_wrap) year_d = yr_wrap ? 8'h00 : bcd_inc(year_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dow_q   <= 8'd1;
      date_q  <= 8'h01;
      month_q <= 8'h01;
      year_q  <= 8'h00;
    end else begin
      dow_q   <= dow_d;
      date_q  <= date_d;
      month_q <= month_d;
      year_q  <= year_d;
    end
  end

  assign dow_o   = dow_q;
  assign date_o  = date_q;
  assign month_o = month_q;
  assign year_o  = year_q;

  AST_DOW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (day_inc && !we_dow && dow_q >= 8'd1 && dow_q <= 8'd7) |=> (dow_q >= 8'd1 && dow_q <= 8'd7)); // R4

  AST_DATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (day_inc && !we_date) |=> (date_q != 8'h00)); // R5

  AST_CENTURY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (day_inc && !we_month && cent_flip) |=> (month_q[MON_CENT_BIT] != $past(month_q[MON_CENT_BIT]))); // R6

  AST_CENTURY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_month && !(day_inc && cent_flip)) |=> $stable(month_q[MON_CENT_BIT])); // R6

endmodule

// File: rtl/bcd_clock_calendar.sv
module bcd_clock_calendar
  import bcd_clk_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       sec_strobe,
  output logic       half_sec_pulse
);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Write address decode, one enable per register
  logic [NUM_REGS-1:0] we;
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_wdec
    assign we[g] = wr_en && (wr_addr == 3'(g));
  end

  logic one_sec, advance, day_carry;
  logic strobe_q, strobe_d;

  assign advance  = one_sec && !wr_en;
  assign strobe_d = advance;

  clk_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick_en    (tick_en),
    .restart    (we[IDX_SEC]),
    .one_sec    (one_sec),
    .half_pulse (half_sec_pulse)
  );

  bcd_time_chain u_time (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .adv       (advance),
    .we_sec    (we[IDX_SEC]),
    .we_min    (we[IDX_MIN]),
    .we_hour   (we[IDX_HOUR]),
    .wr_data   (wr_data),
    .sec_o     (sec_o),
    .min_o     (min_o),
    .hour_o    (hour_o),
    .day_carry (day_carry)
  );

  bcd_date_chain u_date (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .day_inc  (day_carry),
    .we_dow   (we[IDX_DOW]),
    .we_date  (we[IDX_DATE]),
    .we_month (we[IDX_MONTH]),
    .we_year  (we[IDX_YEAR]),
    .wr_data  (wr_data),
    .dow_o    (dow_o),
    .date_o   (date_o),
    .month_o  (month_o),
    .year_o   (year_o)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) strobe_q <= 1'b0;
    else             strobe_q <= strobe_d;
  end

  assign sec_strobe = strobe_q;

  AST_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |=> !sec_strobe); // R9

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sec_strobe |=> !sec_strobe); // R7

endmodule

// File: tb/bcd_clock_calendar_bench.sv
module bcd_clock_calendar_bench;

  localparam int TPS = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
  logic       sec_strobe, half_sec_pulse;

  always #4 clk = ~clk; // 125 MHz

  bcd_clock_calendar #(.TICKS_PER_SEC(TPS)) u_bcd_clock_calendar (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o),
    .sec_strobe(sec_strobe), .half_sec_pulse(half_sec_pulse)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit armed = 0;

  logic [55:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: each strobe is matched against the next expected snapshot
  always @(negedge clk) begin
    if (armed && sec_strobe) begin
      if (exp_q.size() == 0) begin
        chk("R7 unexpected strobe", 32'd1, 32'd0);
      end else begin
        logic [55:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {24'd0, sec_o},   {24'd0, e[55:48]});
        chk(t, {24'd0, min_o},   {24'd0, e[47:40]});
        chk(t, {24'd0, hour_o},  {24'd0, e[39:32]});
        chk(t, {24'd0, dow_o},   {24'd0, e[31:24]});
        chk(t, {24'd0, date_o},  {24'd0, e[23:16]});
        chk(t, {24'd0, month_o}, {24'd0, e[15:8]});
        chk(t, {24'd0, year_o},  {24'd0, e[7:0]});
      end
    end
  end

  task automatic push_exp(input string tag, input logic [7:0] s, m, h, dw, dt, mo, yr);
    exp_q.push_back({s, m, h, dw, dt, mo, yr});
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Loads all registers; seconds last so the prescaler restarts at the end
  task automatic set_time(input logic [7:0] s, m, h, dw, dt, mo, yr);
    wr(3'd1, m); wr(3'd2, h); wr(3'd3, dw); wr(3'd4, dt);
    wr(3'd5, mo); wr(3'd6, yr); wr(3'd0, s);
  endtask

  task automatic drain();
    int guard = 0;
    armed = 1;
    while (exp_q.size() != 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    if (exp_q.size() != 0) chk("R7 missing strobe", 32'd0, 32'd1);
    armed = 0;
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk("watchdog", 32'd1, 32'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 sec",   {24'd0, sec_o},   32'h00);
    chk("R10 min",   {24'd0, min_o},   32'h00);
    chk("R10 hour",  {24'd0, hour_o},  32'h00);
    chk("R10 dow",   {24'd0, dow_o},   32'h01);
    chk("R10 date",  {24'd0, date_o},  32'h01);
    chk("R10 month", {24'd0, month_o}, 32'h01);
    chk("R10 year",  {24'd0, year_o},  32'h00);
    chk("R10 pulses", {30'd0, sec_strobe, half_sec_pulse}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    tick_en = 1'b1;

    // R1 R2 R4 R6: end of century in 24-hour mode
    set_time(8'h58, 8'h59, 8'h23, 8'd7, 8'h31, 8'h12, 8'h99);
    push_exp("R1", 8'h59, 8'h59, 8'h23, 8'd7, 8'h31, 8'h12, 8'h99);
    push_exp("R2 R4 R6 rollover", 8'h00, 8'h00, 8'h00, 8'd1, 8'h01, 8'h81, 8'h00);
    push_exp("R1 after rollover", 8'h01, 8'h00, 8'h00, 8'd1, 8'h01, 8'h81, 8'h00);
    drain();

    // R1: minute carry only
    set_time(8'h59, 8'h14, 8'h09, 8'd2, 8'h10, 8'h05, 8'h30);
    push_exp("R1 minute carry", 8'h00, 8'h15, 8'h09, 8'd2, 8'h10, 8'h05, 8'h30);
    drain();

    // R3: 12-hour steps (0x40 = 12-hour, 0x20 = PM)
    set_time(8'h59, 8'h59, 8'h71, 8'd3, 8'h15, 8'h06, 8'h24);
    push_exp("R3 R4 11PM to 12AM", 8'h00, 8'h00, 8'h52, 8'd4, 8'h16, 8'h06, 8'h24);
    drain();
    set_time(8'h59, 8'h59, 8'h51, 8'd3, 8'h15, 8'h06, 8'h24);
    push_exp("R3 11AM to 12PM", 8'h00, 8'h00, 8'h72, 8'd3, 8'h15, 8'h06, 8'h24);
    drain();
    set_time(8'h59, 8'h59, 8'h72, 8'd3, 8'h15, 8'h06, 8'h24);
    push_exp("R3 12PM to 1PM", 8'h00, 8'h00, 8'h61, 8'd3, 8'h15, 8'h06, 8'h24);
    drain();
    set_time(8'h59, 8'h59, 8'h52, 8'd3, 8'h15, 8'h06, 8'h24);
    push_exp("R3 12AM to 1AM", 8'h00, 8'h00, 8'h41, 8'd3, 8'h15, 8'h06, 8'h24);
    drain();

    // R5: month lengths and leap years
    set_time(8'h59, 8'h59, 8'h23, 8'd2, 8'h28, 8'h02, 8'h24);
    push_exp("R5 leap Feb 28", 8'h00, 8'h00, 8'h00, 8'd3, 8'h29, 8'h02, 8'h24);
    drain();
    set_time(8'h59, 8'h59, 8'h23, 8'd2, 8'h29, 8'h02, 8'h24);
    push_exp("R5 leap Feb 29", 8'h00, 8'h00, 8'h00, 8'd3, 8'h01, 8'h03, 8'h24);
    drain();
    set_time(8'h59, 8'h59, 8'h23, 8'd2, 8'h28, 8'h02, 8'h23);
    push_exp("R5 common Feb 28", 8'h00, 8'h00, 8'h00, 8'd3, 8'h01, 8'h03, 8'h23);
    drain();
    set_time(8'h59, 8'h59, 8'h23, 8'd5, 8'h28, 8'h82, 8'h00);
    push_exp("R5 R6 year 00 leap", 8'h00, 8'h00, 8'h00, 8'd6, 8'h29, 8'h82, 8'h00);
    drain();
    set_time(8'h59, 8'h59, 8'h23, 8'd1, 8'h30, 8'h04, 8'h23);
    push_exp("R5 April 30", 8'h00, 8'h00, 8'h00, 8'd2, 8'h01, 8'h05, 8'h23);
    drain();
    set_time(8'h59, 8'h59, 8'h23, 8'd1, 8'h30, 8'h01, 8'h23);
    push_exp("R5 Jan 30", 8'h00, 8'h00, 8'h00, 8'd2, 8'h31, 8'h01, 8'h23);
    drain();
    set_time(8'h59, 8'h59, 8'h23, 8'd1, 8'h30, 8'h09, 8'h23);
    push_exp("R5 Sep 30", 8'h00, 8'h00, 8'h00, 8'd2, 8'h01, 8'h10, 8'h23);
    drain();

    // R8: seconds write restarts the prescaler; half pulse mid-second
    repeat (3) @(negedge clk);
    wr(3'd0, 8'h30);
    begin
      int n = 0;
      int nh = -1;
      while (!sec_strobe && n < 100) begin
        @(negedge clk);
        n++;
        if (half_sec_pulse && nh < 0) nh = n;
      end
      chk("R8 strobe delay", n, TPS);
      chk("R8 half delay", nh, TPS / 2);
      chk("R8 sec value", {24'd0, sec_o}, 32'h31);
    end

    // R7: ticks held low are not counted
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h40;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
    begin
      int n = 0;
      while (!sec_strobe && n < 100) begin
        @(negedge clk);
        n++;
        if (n == 20) begin
          chk("R7 hold sec", {24'd0, sec_o}, 32'h40);
          tick_en = 1'b1;
        end
      end
      chk("R7 gated delay", n, 20 + TPS);
      chk("R7 gated sec", {24'd0, sec_o}, 32'h41);
    end

    // R9: write on the due cycle drops that advance; masks; address 7 ignored
    wr(3'd0, 8'h10);
    begin
      int n = 0;
      bit early = 0;
      while (!sec_strobe && n < 100) begin
        if (n == TPS - 1) begin
          wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'hB7;
        end
        @(negedge clk);
        n++;
        if (n == TPS) begin
          wr_en = 1'b0;
          chk("R9 min masked", {24'd0, min_o}, 32'h37);
          chk("R9 sec held", {24'd0, sec_o}, 32'h10);
        end
        if (sec_strobe && n <= TPS) early = 1;
      end
      chk("R9 no strobe on write", {31'd0, early}, 32'd0);
      chk("R9 delayed advance", n, 2 * TPS);
      chk("R9 sec after", {24'd0, sec_o}, 32'h11);
    end
    begin
      logic [55:0] snap;
      @(negedge clk);
      snap = {sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o};
      wr(3'd7, 8'hFF);
      chk("R9 addr 7 ignored lo", snap[31:0],
          {dow_o, date_o, month_o, year_o});
      chk("R9 addr 7 ignored hi", {8'd0, snap[55:32]},
          {8'd0, sec_o, min_o, hour_o});
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule